// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address to a physical address after a translation miss. It reads a page table held in ordinary memory. A walk starts from the context table. The entry address comes from a 4-bit context number and a table-pointer register. The walk then follows table descriptors through a 256-entry first level and two 64-entry lower levels, and ends at a page entry. All table reads and the single optional write go through one word-wide memory port, which carries one request at a time.

At the page entry the walker checks a three-bit access code against the mode of the request (user or supervisor) and its direction (read or write). On success it writes back the referenced bit, and the modified bit for a write, but only when one of them is not yet set. It then returns a 36-bit physical address. If the walk stops early it returns a fault instead, with the level at which it stopped and a cause code. The walker handles one walk at a time. A new request can be taken in the same cycle that the previous result is presented.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `resp_valid` are all 0.
- R2: The first read of a walk uses byte address (`ctx_ptr` with bits 1:0 dropped, shifted left by 6) OR (`ctx_num` shifted left by 2).
- R3: When a descriptor D is found, the next read uses byte address 4 × ((D with bits 1:0 cleared) × 16 + index). The index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: Bits 1:0 of an entry give its type: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. Levels 0–2 must give type 1 and level 3 must give type 2. Any other type ends the walk with a fault.
- R5: A fault sets `resp_fault` = 1 and `resp_level` = the level (0–3) of the entry that stopped the walk. `resp_cause` is 1 for an invalid entry, 2 for a reserved or wrong type, and 3 for a protection violation. A faulting walk writes nothing to memory.
- R6: The access code is in bits 4:2 of the page entry. A user access faults when the code is 6 or 7. A user write is allowed only for codes 1 and 3. A supervisor write is allowed only for codes 1, 3, 5 and 7. Reads not excluded by these rules succeed.
- R7: On success `resp_fault` = 0, `resp_cause` = 0, `resp_level` = 3 and `resp_pa` = {entry[31:8], va[11:0]}.
- R8: On success the updated entry is the old entry OR bit 5 (referenced), OR bit 6 (modified) for a write. It is written once to the page entry's address if it differs from the old entry; otherwise nothing is written.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. Only one access is outstanding at a time.
- R10: `resp_valid` is a one-cycle pulse. A request is taken only while `busy` is 0, and a request raised while `busy` is 1 is ignored. A request raised in the cycle `resp_valid` is high is accepted at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Start a walk (taken while idle) |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| busy | output | 1 | A walk is in progress |
| ctx_num | input | 4 | Current context number |
| ctx_ptr | input | 32 | Context table pointer register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 38 | Byte address of the entry |
| mem_wdata | output | 32 | Updated page entry |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_level | output | 2 | Level where the walk stopped |
| resp_cause | output | 2 | 0 none, 1 invalid, 2 bad type, 3 protection |
| resp_pa | output | 36 | Physical address |

## Verification
Two functions can fall in the same cycle: the result of one walk is presented, and the next request is accepted. The bench raises a second request exactly in the cycle where `resp_valid` is high. It checks that `busy` is high in the following cycle, and that both walks return the values and memory traffic computed for them. A request pulsed in the middle of the first walk is also checked: it must leave no trace in either result or in the access log.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } entry_type_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_INVALID = 2'd1,
    FC_BADTYPE = 2'd2,
    FC_PROT    = 2'd3
  } fault_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WBACK = 2'd2
  } walk_state_e;

  localparam int ENT_W   = 32;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int ACC_LSB = 2;
  localparam int ACC_W   = 3;
  localparam int PPN_LSB = 8;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int CTX_W = 4,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int OFF_W = 12,
  localparam int ENT_W = ptw_pkg::ENT_W,
  localparam int VA_W  = L1_W + L2_W + L3_W + OFF_W,
  localparam int AW    = ENT_W + 6,
  localparam int BW    = AW - 2
) (
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [ENT_W-1:0] ctx_ptr,
  input  logic [ENT_W-1:0] desc,
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       tgt_lvl,
  output logic [AW-1:0]    ctx_addr,
  output logic [AW-1:0]    next_addr
);
  logic [ENT_W+3:0] ptr_part;
  logic [ENT_W+3:0] ctx_part;
  logic [BW-1:0]    base_w;
  logic [BW-1:0]    idx_ext;
  logic [BW-1:0]    word;

  assign ptr_part = {ctx_ptr[ENT_W-1:2], 6'b0};
  assign ctx_part = {{(ENT_W+2-CTX_W){1'b0}}, ctx_num, 2'b00};
  assign ctx_addr = {2'b00, ptr_part | ctx_part};

  // next table base: pointer field with type bits cleared, times 16 words
  assign base_w = {desc[ENT_W-1:2], 6'b0};

  always_comb begin
    unique case (tgt_lvl)
      2'd1:    idx_ext = BW'(va[VA_W-1 -: L1_W]);
      2'd2:    idx_ext = BW'(va[OFF_W+L3_W +: L2_W]);
      default: idx_ext = BW'(va[OFF_W +: L3_W]);
    endcase
  end

  assign word      = base_w + idx_ext;
  assign next_addr = {word, 2'b00};
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [ACC_W-1:0] code,
  input  logic             user,
  input  logic             write,
  output logic             prot_fault
);
  logic user_blocked;
  logic wr_ok;

  // codes 6 and 7 carry no user rights
  assign user_blocked = user && (code > 3'd5);

  always_comb begin
    if (user) wr_ok = (code == 3'd1) || (code == 3'd3);
    else      wr_ok = code[0];
  end

  assign prot_fault = user_blocked || (write && !wr_ok);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 4,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int OFF_W = 12,
  localparam int VA_W = L1_W + L2_W + L3_W + OFF_W,
  localparam int AW   = ENT_W + 6,
  localparam int PA_W = ENT_W - PPN_LSB + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             busy,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [ENT_W-1:0] ctx_ptr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [1:0]       resp_level,
  output logic [1:0]       resp_cause,
  output logic [PA_W-1:0]  resp_pa
);
  walk_state_e      state_q, state_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [ENT_W-1:0] wdata_q, wdata_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic             accept;
  logic             rv_d, rf_d;
  logic [1:0]       rl_d, rc_d;
  logic [PA_W-1:0]  pa_d;

  logic [AW-1:0]    ctx_addr, next_addr;
  logic             prot_fault;
  entry_type_e      etype;
  logic             last_lvl;
  logic [ENT_W-1:0] upd;

  ptw_addr #(
    .CTX_W(CTX_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .OFF_W(OFF_W)
  ) u_addr (
    .ctx_num  (ctx_num),
    .ctx_ptr  (ctx_ptr),
    .desc     (mem_rdata),
    .va       (va_q),
    .tgt_lvl  (lvl_q + 2'd1),
    .ctx_addr (ctx_addr),
    .next_addr(next_addr)
  );

  ptw_perm u_perm (
    .code      (mem_rdata[ACC_LSB +: ACC_W]),
    .user      (usr_q),
    .write     (wr_q),
    .prot_fault(prot_fault)
  );

  assign etype    = entry_type_e'(mem_rdata[1:0]);
  assign last_lvl = (lvl_q == 2'd3);
  assign upd      = mem_rdata | (ENT_W'(1) << REF_BIT) | (ENT_W'(wr_q) << MOD_BIT);
  assign accept   = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rv_d    = 1'b0;
    rf_d    = resp_fault;
    rl_d    = resp_level;
    rc_d    = resp_cause;
    pa_d    = resp_pa;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_READ;
          lvl_d   = 2'd0;
          addr_d  = ctx_addr;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (!last_lvl && etype == ET_TABLE) begin
            lvl_d  = lvl_q + 2'd1;
            addr_d = next_addr;
          end else if (last_lvl && etype == ET_PAGE && !prot_fault) begin
            rf_d = 1'b0;
            rl_d = lvl_q;
            rc_d = FC_NONE;
            pa_d = {mem_rdata[ENT_W-1:PPN_LSB], va_q[OFF_W-1:0]};
            if (upd != mem_rdata) begin
              state_d = ST_WBACK;
              wdata_d = upd;
            end else begin
              state_d = ST_IDLE;
              rv_d    = 1'b1;
            end
          end else begin
            state_d = ST_IDLE;
            rv_d    = 1'b1;
            rf_d    = 1'b1;
            rl_d    = lvl_q;
            if (etype == ET_INVALID)                     rc_d = FC_INVALID;
            else if (last_lvl && etype == ET_PAGE)       rc_d = FC_PROT;
            else                                         rc_d = FC_BADTYPE;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
          rv_d    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lvl_q      <= 2'd0;
      addr_q     <= '0;
      wdata_q    <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_level <= 2'd0;
      resp_cause <= 2'd0;
      resp_pa    <= '0;
    end else begin
      state_q    <= state_d;
      lvl_q      <= lvl_d;
      addr_q     <= addr_d;
      wdata_q    <= wdata_d;
      resp_valid <= rv_d;
      resp_fault <= rf_d;
      resp_level <= rl_d;
      resp_cause <= rc_d;
      resp_pa    <= pa_d;
      if (accept) begin
        va_q  <= req_va;
        wr_q  <= req_write;
        usr_q <= req_user;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WBACK);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  wb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> !mem_we);

  // R8
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[REF_BIT] && (mem_wdata[1:0] == 2'b10));

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R5
  prot_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_cause == FC_PROT) |-> resp_fault && (resp_level == 2'd3));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          fault;
    logic [1:0]  level;
    logic [1:0]  cause;
    logic [35:0] pa;
    int          nacc;
    logic [37:0] addr [4];
    bit          wb;
    logic [31:0] wdata;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user;
  logic [31:0] req_va;
  logic        busy;
  logic [3:0]  ctx_num;
  logic [31:0] ctx_ptr;
  logic        mem_req, mem_we, mem_ack;
  logic [37:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        resp_valid, resp_fault;
  logic [1:0]  resp_level, resp_cause;
  logic [35:0] resp_pa;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mem [0:4095];
  logic [37:0] log_addr [0:7];
  logic        log_we   [0:7];
  logic [31:0] log_data [0:7];
  int          log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .busy(busy),
    .ctx_num(ctx_num), .ctx_ptr(ctx_ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_level(resp_level), .resp_cause(resp_cause), .resp_pa(resp_pa)
  );

  // memory model: answers one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      log_addr[log_n % 8] <= mem_addr;
      log_we[log_n % 8]   <= mem_we;
      log_data[log_n % 8] <= mem_wdata;
      log_n <= log_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [37:0] va_index(input logic [31:0] va, input int lvl);
    if (lvl == 1)      return 38'(va[31:24]);
    else if (lvl == 2) return 38'(va[23:18]);
    else               return 38'(va[17:12]);
  endfunction

  // lays out the entries a walk will meet and computes its outcome
  task automatic prep(input logic [3:0] ctx, input logic [31:0] ptr,
                      input logic [31:0] va, input bit w, input bit u,
                      input logic [31:0] e0, input logic [31:0] e1,
                      input logic [31:0] e2, input logic [31:0] e3,
                      output exp_t x);
    logic [31:0] e [4];
    logic [31:0] upd;
    logic [2:0]  code;
    bit          uw, sw, prot;
    e = '{e0, e1, e2, e3};
    x.fault = 1'b0; x.cause = 2'd0; x.level = 2'd0; x.pa = '0;
    x.wb = 1'b0; x.wdata = '0; x.nacc = 0;
    x.addr[0] = ((38'(ptr) >> 2) << 6) | (38'(ctx) << 2);
    for (int k = 0; k < 4; k++) begin
      mem[x.addr[k][13:2]] = e[k];
      x.level = 2'(k);
      x.nacc  = k + 1;
      if (k < 3) begin
        if (e[k][1:0] == 2'd1) begin
          x.addr[k+1] = (((38'(e[k]) >> 2) << 6) + va_index(va, k + 1)) * 4;
        end else begin
          x.fault = 1'b1;
          x.cause = (e[k][1:0] == 2'd0) ? 2'd1 : 2'd2;
          break;
        end
      end else if (e[k][1:0] != 2'd2) begin
        x.fault = 1'b1;
        x.cause = (e[k][1:0] == 2'd0) ? 2'd1 : 2'd2;
      end else begin
        code = e[k][4:2];
        uw   = (code == 3'd1) || (code == 3'd3);
        sw   = (code == 3'd1) || (code == 3'd3) || (code == 3'd5) || (code == 3'd7);
        prot = (u && code >= 3'd6) || (w && !(u ? uw : sw));
        if (prot) begin
          x.fault = 1'b1;
          x.cause = 2'd3;
        end else begin
          x.pa    = {e[k][31:8], va[11:0]};
          upd     = e[k] | 32'h20 | (w ? 32'h40 : 32'h0);
          x.wb    = (upd != e[k]);
          x.wdata = upd;
          if (x.wb) x.nacc = 5;
        end
      end
    end
  endtask

  task automatic verify(input exp_t x, input int start, input string tag);
    int got;
    chk(resp_fault == x.fault, "R5", {tag, " fault"}, 64'(resp_fault), 64'(x.fault));
    chk(resp_level == x.level, "R5", {tag, " level"}, 64'(resp_level), 64'(x.level));
    chk(resp_cause == x.cause, "R5", {tag, " cause"}, 64'(resp_cause), 64'(x.cause));
    if (!x.fault)
      chk(resp_pa == x.pa, "R7", {tag, " pa"}, 64'(resp_pa), 64'(x.pa));
    got = log_n - start;
    chk(got == x.nacc, "R8", {tag, " access count"}, 64'(got), 64'(x.nacc));
    if (got == x.nacc) begin
      for (int k = 0; k <= int'(x.level); k++) begin
        chk(log_addr[(start+k)%8] == x.addr[k] && !log_we[(start+k)%8],
            (k == 0) ? "R2" : "R3", {tag, " read addr"},
            64'(log_addr[(start+k)%8]), 64'(x.addr[k]));
      end
      if (x.wb) begin
        chk(log_we[(start+4)%8] && log_addr[(start+4)%8] == x.addr[3], "R8",
            {tag, " wb addr"}, 64'(log_addr[(start+4)%8]), 64'(x.addr[3]));
        chk(log_data[(start+4)%8] == x.wdata, "R8", {tag, " wb data"},
            64'(log_data[(start+4)%8]), 64'(x.wdata));
      end
    end
  endtask

  task automatic issue(input logic [3:0] ctx, input logic [31:0] ptr,
                       input logic [31:0] va, input bit w, input bit u,
                       output int start);
    @(negedge clk);
    ctx_num = ctx; ctx_ptr = ptr; req_va = va; req_write = w; req_user = u;
    req_valid = 1'b1;
    start = log_n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp();
    int n = 0;
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(resp_valid, "R10", "response arrives", 64'(resp_valid), 64'd1);
  endtask

  task automatic walk(input logic [3:0] ctx, input logic [31:0] ptr,
                      input logic [31:0] va, input bit w, input bit u,
                      input logic [31:0] e0, input logic [31:0] e1,
                      input logic [31:0] e2, input logic [31:0] e3,
                      input string tag);
    exp_t x;
    int   start;
    prep(ctx, ptr, va, w, u, e0, e1, e2, e3, x);
    issue(ctx, ptr, va, w, u, start);
    wait_resp();
    verify(x, start, tag);
    @(negedge clk);
    chk(!resp_valid, "R10", {tag, " pulse width"}, 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    exp_t xa, xb;
    int   sa, sb;
    logic [31:0] va;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
    req_va = '0; ctx_num = '0; ctx_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy, "R1", "busy after reset", 64'(busy), 64'd0);
    chk(!mem_req, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
    chk(!resp_valid, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);

    // R2 / R4: every context under two pointer values, context entry types varied
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 16; c++) begin
        walk(4'(c), (p == 0) ? 32'h0000_0100 : 32'h0000_0203,
             32'h5A00_0000 + 32'(c << 20), 1'b0, 1'b0,
             32'h10 | 32'(c % 4), 32'h0, 32'h0, 32'h0, "R2 ctx sweep R4");
      end
    end

    // R4: each lower level with each type tag
    for (int l = 1; l < 4; l++) begin
      for (int t = 0; t < 4; t++) begin
        va = {8'(8'h11 * (l + t)), 6'(l * 5 + t), 6'(t * 9 + 3), 12'hABC};
        walk(4'(l), 32'h100, va, 1'b0, 1'b0, 32'h11,
             (l == 1) ? (32'h20 | 32'(t)) : 32'h21,
             (l == 2) ? (32'h30 | 32'(t)) : (l < 2 ? 32'h0 : 32'h31),
             (l == 3) ? (32'hABCD_E000 | 32'(t)) : 32'h0,
             "R4 type sweep R3");
      end
    end

    // R6 / R7 / R8: all access codes, directions, modes and prior R/M states
    for (int code = 0; code < 8; code++) begin
      for (int w = 0; w < 2; w++) begin
        for (int u = 0; u < 2; u++) begin
          for (int rm = 0; rm < 4; rm++) begin
            va = {8'(code * 29 + rm), 6'(w * 17 + u * 7 + rm), 6'(code * 8 + rm), 12'(code * 311 + rm * 97)};
            walk(4'(code + rm), 32'h100, va, 1'(w), 1'(u), 32'h11, 32'h21, 32'h31,
                 {24'(code * 24'h01_2345 + 24'h00_0777), 1'b0, 2'(rm), 3'(code), 2'b10},
                 "R6 perm sweep R7 R8");
          end
        end
      end
    end

    // R10: ignored request while busy; next request taken in the response cycle
    prep(4'd7, 32'h100, 32'h3C04_1123, 1'b1, 1'b0, 32'h11, 32'h21, 32'h31,
         32'h1357_9B0E, xa);
    issue(4'd7, 32'h100, 32'h3C04_1123, 1'b1, 1'b0, sa);
    @(negedge clk);
    req_va = 32'hC3F0_0FFF; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_resp();
    verify(xa, sa, "R10 first walk");
    prep(4'd2, 32'h100, 32'h7E3C_5456, 1'b0, 1'b1, 32'h11, 32'h21, 32'h31,
         32'h2468_ACE2, xb);
    ctx_num = 4'd2; ctx_ptr = 32'h100; req_va = 32'h7E3C_5456;
    req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
    sb = log_n;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R10", "accepted in response cycle", 64'(busy), 64'd1);
    wait_resp();
    verify(xb, sb, "R10 second walk");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule